// File: doc/BRIEF.md
# Scrambling NRZI Word Serializer

This block turns a stream of 10-bit parallel words into a one-bit serial stream running at ten times the word rate. It lives entirely in the bit-clock domain. An internal modulo-10 counter produces a word strobe, and the upstream logic must present the next word on `par_data` while that strobe is high. The loaded word is shifted out least significant bit first.

Each serial bit passes through a self-synchronizing scrambler with generator x^9 + x^4 + 1. The scrambled bit then drives an x + 1 (NRZI) line coder, which inverts the line level for every scrambled one. A single `bypass` input skips both coding stages and sends the raw NRZ bit. The `lock` input reports whether the bit clock is trustworthy. While it is low the output is forced to a fixed level and the NRZI level is frozen. A synchronous active-high reset clears the scrambler history, the line level and the word counter.

The serial level leaves a register as a true/complement pair, ready for a differential driver.

Top module: `sdi_serializer`

## Requirements
- R1: `word_strobe` is high for exactly one cycle in every ten. It is first high in the tenth cycle after reset is released. `par_data` is captured at the rising edge where `word_strobe` is high.
- R2: Bits leave LSB first. With the word captured at edge L, bit k of that word determines the output register value written at edge L+1+k (k = 0..9).
- R3: With `lock`=1 and `bypass`=0, scrambled bit s(n) = d(n) xor s(n-4) xor s(n-9), taken from the scrambled history. The output level then inverts when s(n)=1 and holds when s(n)=0.
- R4: With `lock`=1 and `bypass`=1, the output written at each edge is the raw data bit. The NRZI level is not changed.
- R5: A clock edge with `rst`=1 clears the scrambler history, the NRZI level, the shift register and the word counter, and drives `sd_p` to 0.
- R6: An edge with `lock`=0 writes 0 to `sd_p`. The NRZI level is held, so the first coded bit after relock continues from the level held before the mute. The scrambler history keeps advancing during the mute.
- R7: `sd_n` is always the complement of `sd_p`.
- R8: After reset, an all-zero data stream in coded mode keeps `sd_p` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| par_data | input | 10 | Parallel word, captured when `word_strobe` is high |
| bypass | input | 1 | 1 = send raw NRZ bits, skipping scrambler and NRZI |
| lock | input | 1 | 1 = bit clock valid; 0 = mute the output |
| word_strobe | output | 1 | High in the cycle whose closing edge captures `par_data` |
| sd_p | output | 1 | Serial output, true |
| sd_n | output | 1 | Serial output, complement |

## Verification
The hardest situation to reach from the ports is a mode change in the middle of a word. If `lock` or `bypass` changes while a word is half shifted out, the scrambler history and the frozen NRZI level must carry over correctly. The stimulus table changes mode only at word strobes. Because coding runs one cycle behind the shift register, each change still lands on the last bit of the previous word. That drives mute-to-coded and bypass-to-coded handovers with a live nine-bit history. A cycle-exact reference model compares every output bit across those boundaries.

// File: rtl/sdi_ser_pkg.sv
package sdi_ser_pkg;
  localparam int WORD_W  = 10;
  localparam int SCR_LEN = 9;
  localparam int SCR_TAP = 4;
  localparam logic MUTE_LEVEL = 1'b0;
endpackage

// File: rtl/sdi_word_shifter.sv
module sdi_word_shifter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] word_i,
  output logic         load_o,
  output logic         bit_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  shr_q;

  assign load_o = (cnt_q == LAST);
  assign bit_o  = shr_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      shr_q <= '0;
    end else if (load_o) begin
      cnt_q <= '0;
      shr_q <= word_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      shr_q <= {1'b0, shr_q[W-1:1]};
    end
  end
endmodule

// File: rtl/sdi_self_sync_scrambler.sv
module sdi_self_sync_scrambler #(
  parameter int LEN = 9,
  parameter int TAP = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           d_i,
  output logic           s_o,
  output logic [LEN-1:0] hist_o
);
  logic [LEN-1:0] hist_q;

  assign s_o    = d_i ^ hist_q[TAP-1] ^ hist_q[LEN-1];
  assign hist_o = hist_q;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= {hist_q[LEN-2:0], s_o};
  end
endmodule

// File: rtl/sdi_line_coder.sv
module sdi_line_coder #(
  parameter logic MUTE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic scr_i,
  input  logic bypass_i,
  input  logic lock_i,
  output logic sd_o
);
  logic nrzi_q;
  logic nrzi_next;
  logic out_q;

  assign nrzi_next = nrzi_q ^ scr_i;
  assign sd_o      = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nrzi_q <= 1'b0;
      out_q  <= MUTE;
    end else if (!lock_i) begin
      out_q  <= MUTE;
    end else if (bypass_i) begin
      out_q  <= raw_i;
    end else begin
      nrzi_q <= nrzi_next;
      out_q  <= nrzi_next;
    end
  end
endmodule

// File: rtl/sdi_serializer.sv
module sdi_serializer
  import sdi_ser_pkg::*;
#(
  parameter int   W      = WORD_W,
  parameter int   LEN    = SCR_LEN,
  parameter int   TAP    = SCR_TAP,
  parameter logic MUTE   = MUTE_LEVEL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] par_data,
  input  logic         bypass,
  input  logic         lock,
  output logic         word_strobe,
  output logic         sd_p,
  output logic         sd_n
);
  logic           bit_w;
  logic           scr_w;
  logic [LEN-1:0] hist_w;
  logic           line_w;

  sdi_word_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .word_i(par_data),
    .load_o(word_strobe), .bit_o(bit_w)
  );

  sdi_self_sync_scrambler #(.LEN(LEN), .TAP(TAP)) u_scr (
    .clk(clk), .rst(rst), .d_i(bit_w), .s_o(scr_w), .hist_o(hist_w)
  );

  sdi_line_coder #(.MUTE(MUTE)) u_line (
    .clk(clk), .rst(rst), .raw_i(bit_w), .scr_i(scr_w),
    .bypass_i(bypass), .lock_i(lock), .sd_o(line_w)
  );

  assign sd_p = line_w;
  assign sd_n = ~line_w;
endmodule

// File: rtl/sdi_serializer_chk.sv
module sdi_serializer_chk #(
  parameter int W   = 10,
  parameter int LEN = 9
) (
  input logic           clk,
  input logic           rst,
  input logic           lock,
  input logic           bypass,
  input logic           word_strobe,
  input logic           sd_p,
  input logic           sd_n,
  input logic           cur_bit,
  input logic           scr_bit,
  input logic [LEN-1:0] scr_state
);
  localparam int GW = $clog2(W + 1) + 1;
  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic          prev_coded_q;
  logic          coded;

  assign coded = lock && !bypass;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q        <= '0;
      seen_q       <= 1'b0;
      prev_coded_q <= 1'b0;
    end else begin
      prev_coded_q <= coded;
      if (word_strobe) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != {GW{1'b1}}) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  p_strobe_period_r1: assert property (@(posedge clk) disable iff (rst)
    (word_strobe && seen_q) |-> (gap_q == GW'(W - 1)));

  p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
    word_strobe |=> !word_strobe);

  p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (coded && prev_coded_q && scr_bit) |=> (sd_p != $past(sd_p)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (coded && prev_coded_q && !scr_bit) |=> $stable(sd_p));

  p_raw_r4: assert property (@(posedge clk) disable iff (rst)
    (lock && bypass) |=> (sd_p == $past(cur_bit)));

  p_clear_r5: assert property (@(posedge clk)
    rst |=> (sd_p == 1'b0 && scr_state == '0));

  p_mute_r6: assert property (@(posedge clk) disable iff (rst)
    !lock |=> (sd_p == 1'b0));

  p_pair_r7: assert property (@(negedge clk) disable iff (rst)
    sd_n == !sd_p);
endmodule

bind sdi_serializer sdi_serializer_chk #(.W(W), .LEN(LEN)) chk_i (
  .clk(clk), .rst(rst), .lock(lock), .bypass(bypass),
  .word_strobe(word_strobe), .sd_p(sd_p), .sd_n(sd_n),
  .cur_bit(bit_w), .scr_bit(scr_w), .scr_state(hist_w)
);

// File: tb/sdi_serializer_tb_top.sv
`timescale 1ns/1ps
module sdi_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] par_data = '0;
  logic       bypass = 1'b0;
  logic       lock = 1'b1;
  logic       word_strobe, sd_p, sd_n;

  int total = 0;
  int bad   = 0;
  bit chk_en = 1'b0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sdi_serializer dut_i (
    .clk(clk), .rst(rst), .par_data(par_data), .bypass(bypass), .lock(lock),
    .word_strobe(word_strobe), .sd_p(sd_p), .sd_n(sd_n)
  );

  // Reference model from R1..R6, advanced at each rising edge from stable inputs.
  logic [3:0] m_cnt;
  logic [9:0] m_shr;
  logic [8:0] m_hist;
  logic       m_nrzi, m_sd;

  always @(posedge clk) begin
    logic d, s;
    if (rst) begin
      m_cnt = '0; m_shr = '0; m_hist = '0; m_nrzi = 1'b0; m_sd = 1'b0;
    end else begin
      d = m_shr[0];
      s = d ^ m_hist[3] ^ m_hist[8];
      m_hist = {m_hist[7:0], s};
      if (lock && !bypass) m_nrzi = m_nrzi ^ s;
      m_sd = !lock ? 1'b0 : (bypass ? d : m_nrzi);
      if (m_cnt == 4'd9) begin m_shr = par_data; m_cnt = '0; end
      else begin m_shr = {1'b0, m_shr[9:1]}; m_cnt = m_cnt + 1'b1; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison with the model.
  always @(negedge clk) begin
    if (chk_en && !rst) begin
      check(sd_p == m_sd, !lock ? "R6 mute" : (bypass ? "R4 raw" : "R3 coded"), sd_p, m_sd);
      check(sd_n == !m_sd, "R7 complement", sd_n, !m_sd);
      check(word_strobe == (m_cnt == 4'd9), "R1 strobe", word_strobe, m_cnt == 4'd9);
    end
  end

  // {bypass, lock, word}
  localparam logic [11:0] VEC [10] = '{
    {2'b01, 10'h3FF}, {2'b01, 10'h000}, {2'b01, 10'h200}, {2'b01, 10'h155},
    {2'b11, 10'h2AA}, {2'b01, 10'h0F0}, {2'b00, 10'h0F0}, {2'b00, 10'h1C3},
    {2'b01, 10'h3FC}, {2'b01, 10'h001}
  };

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_strobe();
    @(negedge clk);
    while (!word_strobe) @(negedge clk);
  endtask

  initial begin : stim
    int cyc;
    repeat (3) @(negedge clk);
    // R5, R7: reset state
    check(sd_p == 1'b0, "R5 reset sd_p", sd_p, 0);
    check(sd_n == 1'b1, "R7 reset sd_n", sd_n, 1);
    check(word_strobe == 1'b0, "R1 reset strobe", word_strobe, 0);
    rst = 1'b0;
    chk_en = 1'b1;
    // R1: first strobe in the tenth cycle after reset release
    cyc = 1;
    while (!word_strobe && cyc < 20) begin @(negedge clk); cyc++; end
    check(cyc == 10, "R1 first strobe cycle", cyc, 10);

    // Table walk: modes change at word boundaries
    for (int i = 0; i < 10; i++) begin
      wait_strobe();
      {bypass, lock, par_data} = VEC[i];
    end
    repeat (12) @(negedge clk);

    // R2, R4: bypass sends raw bits LSB first
    bypass = 1'b1; lock = 1'b1;
    wait_strobe();
    par_data = 10'h2B5;
    @(posedge clk);
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); @(negedge clk);
      check(sd_p == par_data[k], "R2 LSB-first bit", sd_p, par_data[k]);
    end

    // R6: mute holds the output low for a whole stretch
    bypass = 1'b0; par_data = 10'h3A7;
    @(negedge clk); lock = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 15; k++) begin
      check(sd_p == 1'b0, "R6 muted level", sd_p, 0);
      @(negedge clk);
    end
    lock = 1'b1;
    repeat (25) @(negedge clk);

    // R8: zero data after reset stays at zero
    par_data = '0; bypass = 1'b0; lock = 1'b1;
    do_reset();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      check(sd_p == 1'b0, "R8 zero stream", sd_p, 0);
    end

    // R5: reset in mid-stream clears coding state
    par_data = 10'h3FF;
    repeat (23) @(negedge clk);
    do_reset();
    @(negedge clk);
    check(sd_p == 1'b0, "R5 post-reset level", sd_p, 0);
    repeat (30) @(negedge clk);

    chk_en = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule